// File: doc/BRIEF.md
# Three-Line Interrupt Event Controller

This block gathers single-cycle event pulses from a network DMA engine into a 32-bit event register. Each bit is set by hardware and cleared by software writing one to it. A 32-bit enable mask sits beside the event register. Three level-sensitive interrupt lines come out of the block, one each for transmit, receive and error events. A line is high while at least one event in its group is both pending and enabled. It falls once software has cleared, or masked off, every such event.

Software reaches the block through a single-cycle write port and a combinational read port. The write port selects either the event register or the mask register. The read port selects which of the two registers appears on the read data. The two graceful-stop-done events belong to the error group, and each is gated by its own enable bit, like every other event.

Event bit layout: bit 0 is the transmit frame event, the only member of the transmit group. Bit 1 is the receive frame event, the only member of the receive group. Bits 2 to 22 form the error group:

| Bit | Event |
|-----|-------|
| 2 | wake packet |
| 3 | graceful transmit stop done |
| 4 | graceful receive stop done |
| 5 | transmit control |
| 6 | receive control |
| 7 | babbling receive |
| 8 | babbling transmit |
| 9 | late collision |
| 10 | retry limit |
| 11 to 13 | three filer events |
| 14 | data parity |
| 15 | receive parity |
| 16 | bus error |
| 17 | transmit error |
| 18 | underrun |
| 19 | busy |
| 20 to 22 | three management-statistics events |

Bits 23 to 31 are not implemented.

Top module: `irq_event_ctrl`

## Requirements
- R1: A one on `evtSet[i]` for an implemented bit i (0 to 22) sets event bit i at the next rising clock edge. Event bits 23 to 31 always read zero, whatever is pulsed on them.
- R2: A write with `wrEn`=1 and `wrSel`=0 to the event register clears each event bit whose `wrData` bit is one, and leaves each bit whose `wrData` bit is zero unchanged.
- R3: When a hardware set and a software clear hit the same event bit in the same cycle, the bit is set after the edge.
- R4: A write with `wrEn`=1 and `wrSel`=1 loads all 32 bits of `wrData` into the mask register. A mask write leaves the event register unchanged.
- R5: `rdData` shows the event register when `rdSel`=0 and the mask register when `rdSel`=1, combinationally from the current register state.
- R6: `irqTx` is registered. At each edge it takes the value (event bit 0 AND mask bit 0) as held before that edge. It is therefore low while bit 0 is pending but masked, and it falls one edge after bit 0 is cleared.
- R7: `irqRx` follows the same rule as `irqTx`, using event bit 1 and mask bit 1.
- R8: `irqErr` is registered. At each edge it takes the OR over bits 2 to 22 of (event AND mask). It stays high until every enabled pending error-group bit is clear.
- R9: The graceful transmit stop done event (bit 3) and graceful receive stop done event (bit 4) assert `irqErr` only while their own mask bit is set. Both bits stay pending while masked.
- R10: After reset, the event register, the mask register and all three interrupt lines are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| evtSet | input | 32 | Per-bit hardware event set pulses |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 selects the event register (write one to clear), 1 selects the mask register |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read source: 0 selects the event register, 1 selects the mask register |
| rdData | output | 32 | Read data |
| irqTx | output | 1 | Transmit interrupt line |
| irqRx | output | 1 | Receive interrupt line |
| irqErr | output | 1 | Error interrupt line |

## Verification
Two functions can act on the same event bit in the same cycle: a hardware set pulse and a software write-one-to-clear. The bench provokes this collision in directed steps, with pulses and clear writes overlapping on identical and on partly shared bits. A long pseudo-random stretch then overlaps set pulses, clear writes and mask writes freely. On every clock the bench judges the outcome against a behavioural model in which the set wins. The comparison covers the read-back of both registers and the three interrupt lines one edge later.

// File: rtl/irq_event_pkg.sv
package irq_event_pkg;

  localparam int unsigned EVT_W = 32;

  typedef enum logic {
    SEL_EVENT = 1'b0,
    SEL_MASK  = 1'b1
  } regSel_e;

  typedef struct packed {
    logic clrEvt;
    logic ldMask;
  } regStrobe_t;

  localparam logic [EVT_W-1:0] GRP_TX  = 32'h0000_0001;
  localparam logic [EVT_W-1:0] GRP_RX  = 32'h0000_0002;
  localparam logic [EVT_W-1:0] GRP_ERR = 32'h007F_FFFC;

  localparam int unsigned LINE_N = 3;

endpackage

// File: rtl/irq_event_decode.sv
module irq_event_decode
  import irq_event_pkg::*;
(
  input  logic       wrEn,
  input  logic       wrSel,
  output regStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      if (regSel_e'(wrSel) == SEL_EVENT) strobe.clrEvt = 1'b1;
      else                               strobe.ldMask = 1'b1;
    end
  end

endmodule

// File: rtl/irq_event_regs.sv
module irq_event_regs
  import irq_event_pkg::*;
#(
  parameter int unsigned W = EVT_W,
  parameter logic [W-1:0] TX_BITS  = GRP_TX,
  parameter logic [W-1:0] RX_BITS  = GRP_RX,
  parameter logic [W-1:0] ERR_BITS = GRP_ERR,
  parameter int unsigned LINES = LINE_N
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [W-1:0]     wrData,
  input  logic [W-1:0]     evtSet,
  input  logic             rdSel,
  output logic [W-1:0]     rdData,
  output logic [LINES-1:0] irqVec
);

  localparam logic [W-1:0] IMPL = TX_BITS | RX_BITS | ERR_BITS;
  localparam logic [LINES*W-1:0] GROUPS = {ERR_BITS, RX_BITS, TX_BITS};

  logic [W-1:0] evtQ;
  logic [W-1:0] maskQ;
  logic [W-1:0] evtNext;
  logic [W-1:0] pendEn;

  always_comb begin
    evtNext = evtQ;
    if (strobe.clrEvt) evtNext = evtNext & ~wrData;
    evtNext = (evtNext | evtSet) & IMPL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ  <= '0;
      maskQ <= '0;
    end else begin
      evtQ <= evtNext;
      if (strobe.ldMask) maskQ <= wrData;
    end
  end

  assign pendEn = evtQ & maskQ;
  assign rdData = rdSel ? maskQ : evtQ;

  for (genvar g = 0; g < LINES; g++) begin : gLine
    localparam logic [W-1:0] SEL = GROUPS[g*W +: W];
    logic lineQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lineQ <= 1'b0;
      else       lineQ <= |(pendEn & SEL);
    end
    assign irqVec[g] = lineQ;

    // R6 R7 R8: a line is low one edge after its group has nothing enabled pending
    a_r8_line_drops: assert property (@(posedge clk) disable iff (!rstN)
      ((pendEn & SEL) == '0) |=> !lineQ);
    a_r8_line_rises: assert property (@(posedge clk) disable iff (!rstN)
      ((pendEn & SEL) != '0) |=> lineQ);
  end

  // R1: a pulsed implemented bit is set after the edge
  a_r1_set_lands: assert property (@(posedge clk) disable iff (!rstN)
    ((evtSet & IMPL) != '0) |=> ((evtQ & $past(evtSet & IMPL)) == $past(evtSet & IMPL)));

  // R1: unimplemented bits stay clear
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (evtQ & ~IMPL) == '0);

  // R2: written-one bits without a simultaneous set are cleared
  a_r2_clear_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEvt |=> ((evtQ & $past(wrData & ~evtSet)) == '0));

  // R4: mask write loads and leaves events untouched
  a_r4_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldMask |=> (maskQ == $past(wrData)));
  a_r4_mask_no_evt: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldMask && (evtSet == '0)) |=> $stable(evtQ));

endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_event_pkg::*;
#(
  parameter int unsigned W = EVT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] evtSet,
  input  logic         wrEn,
  input  logic         wrSel,
  input  logic [W-1:0] wrData,
  input  logic         rdSel,
  output logic [W-1:0] rdData,
  output logic         irqTx,
  output logic         irqRx,
  output logic         irqErr
);

  regStrobe_t          strobe;
  logic [LINE_N-1:0]   irqVec;

  irq_event_decode u_decode (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .strobe (strobe)
  );

  irq_event_regs #(
    .W        (W),
    .TX_BITS  (W'(GRP_TX)),
    .RX_BITS  (W'(GRP_RX)),
    .ERR_BITS (W'(GRP_ERR)),
    .LINES    (LINE_N)
  ) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .evtSet (evtSet),
    .rdSel  (rdSel),
    .rdData (rdData),
    .irqVec (irqVec)
  );

  assign irqTx  = irqVec[0];
  assign irqRx  = irqVec[1];
  assign irqErr = irqVec[2];

  // R10: lines low in the first cycle out of reset
  a_r10_lines_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irqTx && !irqRx && !irqErr));

endmodule

// File: tb/irq_event_ctrl_bench.sv
module irq_event_ctrl_bench;

  localparam logic [31:0] M_TX  = 32'h0000_0001;
  localparam logic [31:0] M_RX  = 32'h0000_0002;
  localparam logic [31:0] M_ERR = 32'h007F_FFFC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtSet = '0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;
  logic        irqTx, irqRx, irqErr;

  always #2.5 clk = ~clk;

  irq_event_ctrl u_irq_event_ctrl (
    .clk(clk), .rstN(rstN), .evtSet(evtSet), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .irqTx(irqTx), .irqRx(irqRx), .irqErr(irqErr)
  );

  // behavioural reference model
  logic [31:0] mEvt, mMask;
  logic        mTx, mRx, mErr;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEvt <= 0; mMask <= 0; mTx <= 0; mRx <= 0; mErr <= 0;
    end else begin
      logic [31:0] e;
      e = mEvt;
      if (wrEn && !wrSel) e = e & ~wrData;
      e = e | evtSet;
      mEvt <= e & (M_TX | M_RX | M_ERR);
      if (wrEn && wrSel) mMask <= wrData;
      mTx  <= (mEvt & mMask & M_TX)  != 0;
      mRx  <= (mEvt & mMask & M_RX)  != 0;
      mErr <= (mEvt & mMask & M_ERR) != 0;
    end
  end

  int    nCmp = 0;
  int    nBad = 0;
  string phase = "R10";
  bit    done = 0;

  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] expRd;
      expRd = rdSel ? mMask : mEvt;
      nCmp++;
      if (rdData !== expRd) begin
        nBad++;
        $display("FAIL %s rdData(rdSel=%0d) actual=%h expected=%h", phase, rdSel, rdData, expRd);
      end
      nCmp++;
      if (irqTx !== mTx) begin
        nBad++;
        $display("FAIL %s irqTx actual=%0b expected=%0b", phase, irqTx, mTx);
      end
      nCmp++;
      if (irqRx !== mRx) begin
        nBad++;
        $display("FAIL %s irqRx actual=%0b expected=%0b", phase, irqRx, mRx);
      end
      nCmp++;
      if (irqErr !== mErr) begin
        nBad++;
        $display("FAIL %s irqErr actual=%0b expected=%0b", phase, irqErr, mErr);
      end
    end
  end

  task automatic step(input logic [31:0] s, input logic we, input logic ws,
                      input logic [31:0] d, input logic rs);
    evtSet = s; wrEn = we; wrSel = ws; wrData = d; rdSel = rs;
    @(posedge clk); #1;
    evtSet = '0; wrEn = 1'b0;
  endtask

  task automatic idle(input int n, input logic rs);
    for (int i = 0; i < n; i++) step('0, 0, 0, '0, rs);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #20000;
    nBad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    // R10: reset state
    phase = "R10";
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle(2, 0);
    idle(2, 1);

    // R4 R5: mask load and read back, events untouched
    phase = "R4";
    step('0, 1, 1, 32'hA5A5_5A5A, 1);
    idle(2, 1);
    phase = "R5";
    idle(1, 0);

    // R1: pulses, including unimplemented bits
    phase = "R1";
    step(32'h0000_0001, 0, 0, '0, 0);
    idle(2, 0);            // R6: bit 0 pending but masked (mask bit0 = 0)
    step(32'hFFFF_FFFF, 0, 0, '0, 0);
    idle(2, 0);

    // R6 R7: enable all, then drop tx and rx lines by clearing
    phase = "R6";
    step('0, 1, 1, 32'hFFFF_FFFF, 0);
    idle(2, 0);
    step('0, 1, 0, 32'h0000_0001, 0);
    idle(2, 0);
    phase = "R7";
    step('0, 1, 0, 32'h0000_0002, 0);
    idle(2, 0);

    // R2: clear groups of bits, zeros leave bits
    phase = "R2";
    step('0, 1, 0, 32'h0000_F0F0, 0);
    idle(1, 0);
    step('0, 1, 0, 32'h0000_0000, 0);
    idle(1, 0);

    // R8: error line stays until last enabled bit cleared
    phase = "R8";
    step('0, 1, 0, 32'h007F_0000, 0);
    idle(2, 0);
    step('0, 1, 0, 32'h0000_0F0C, 0);
    idle(2, 0);
    step('0, 1, 0, 32'h0000_00FF, 0);
    idle(3, 0);

    // R3: set and clear of the same bit in one cycle
    phase = "R3";
    step(32'h0000_0003, 1, 0, 32'h0000_0003, 0);
    idle(2, 0);
    step(32'h0000_0204, 1, 0, 32'h0000_0607, 0);
    idle(2, 0);

    // R9: graceful stop done bits gated by own mask bit
    phase = "R9";
    step('0, 1, 0, 32'hFFFF_FFFF, 0);
    step('0, 1, 1, 32'h0000_0008, 1);
    step(32'h0000_0018, 0, 0, '0, 0);
    idle(2, 0);
    step('0, 1, 1, 32'h0000_0000, 1);
    idle(2, 0);
    step('0, 1, 1, 32'h0000_0010, 0);
    idle(2, 0);
    step('0, 1, 0, 32'h0000_0010, 0);
    idle(2, 0);

    // R3: pseudo-random overlap of sets, clears and mask writes
    phase = "R3";
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] s, d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      s = lfsr & {lfsr[7:0], lfsr[31:8]} & {lfsr[15:0], lfsr[31:16]};
      d = {lfsr[3:0], lfsr[31:4]};
      step(lfsr[4] ? s : '0, lfsr[5], lfsr[6] & lfsr[9], d, lfsr[7]);
    end
    idle(3, 0);

    finish_run();
  end

endmodule